// File: doc/BRIEF.md
# Microstepping Stepper Translator

This block keeps the electrical angle of a two-phase stepper motor and turns it into two signed current-level codes. Each code drives the reference input of one phase's current DAC. The angle is held as an index in 1/64 of an electrical cycle. Each accepted rising edge on the step strobe moves the index forward or back. The size of the move comes from a two-bit resolution select, which picks half, quarter, eighth or sixteenth stepping. Direction and resolution are only looked at on the edge that is accepted.

A functional reset parks the index at the 45° home position, where both phases carry 70.7% of full scale. While that reset is held, steps are ignored and the monitor flag is forced low. After reset is released, a settling window of programmable length also ignores steps. At all other times the monitor flag marks the four diagonal positions. A sleep input only drops the drive-enable output, which lets the motor coast. The translator keeps counting steps during sleep, so a controller can preset the starting angle before waking the drivers.

Top module: `stepper_xlator`

## Requirements
- R1: The index moves only when `stepIn` is sampled high at a clock edge after being sampled low at the edge before. Holding `stepIn` steadily high or steadily low leaves both phase codes unchanged.
- R2: `modeSel` sets the increment in 1/64-cycle units: 00 gives 8, 01 gives 4, 10 gives 2 and 11 gives 1. The value is taken at the accepted edge. The move is always made from the current index, with no snapping to the coarser grid.
- R3: At the accepted edge, `dirIn`=1 adds the increment to the index and `dirIn`=0 subtracts it. The index wraps modulo 64.
- R4: Power-up (`rst_n` low) and a functional reset (`resetReq` high at a clock edge) both set the index to 8 (45°). Both phase codes then read 8'h5A.
- R5: While `resetReq` is high, step edges are ignored and `monitor` is 0.
- R6: When `resetReq` is low, `monitor` is 1 exactly when the index is 8, 24, 40 or 56.
- R7: Each phase code has the sign (1 means negative) in bit 7 and round(127·|value|) in bits 6:0. Phase A carries cos(2π·index/64) and phase B carries sin(2π·index/64), so B lags A by 90°. A zero magnitude always has sign 0.
- R8: In half-step mode the positions reached alternate between both phases driven and exactly one phase at zero, giving eight positions per cycle.
- R9: After `rst_n` or `resetReq` is released, steps are ignored at the first SETTLE_CYCLES clock edges. Counting the edges from 0, a rise at edge SETTLE_CYCLES is accepted.
- R10: `driveEn` equals the inverse of `sleepIn` one clock later. Steps are accepted during sleep exactly as they are when awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| stepIn | input | 1 | Step strobe, synchronous to clk; a rise requests one move |
| dirIn | input | 1 | Direction: 1 forward, 0 reverse |
| modeSel | input | 2 | Step resolution select |
| resetReq | input | 1 | Synchronous functional reset to home, active high |
| sleepIn | input | 1 | Sleep request; drops the drive enable |
| phaseA | output | 8 | Phase A code: sign and 7-bit magnitude |
| phaseB | output | 8 | Phase B code: sign and 7-bit magnitude |
| monitor | output | 1 | High at the diagonal positions |
| driveEn | output | 1 | Power stage enable; low while sleeping |

## Verification
The bench targets the settling window edge by edge. A step at edge SETTLE_CYCLES−1 must be dropped and a step at edge SETTLE_CYCLES must land, so an off-by-one counter fails one side or the other. It also steps backward past index 0 at sixteenth resolution, which catches a wrap that saturates or sign-extends. It switches from fine to coarse resolution mid-cycle, which catches a design that snaps to the coarse grid. A step strobe held high for many cycles must advance only once, which catches level-triggered stepping. Steps sent during reset and during sleep show whether reset wrongly lets steps through and whether sleep wrongly freezes the counter. Constrained random steps compare both codes against cos and sin computed in the bench, which exposes table errors, swapped phases and negative zeros.

// File: rtl/xlator_pkg.sv
`timescale 1ns/1ps
package xlator_pkg;

  // Angle index covers one electrical cycle in 1/64 units.
  localparam int IDX_W  = 6;
  localparam int MAG_W  = 7;
  localparam int QSTEPS = 1 << (IDX_W - 2);
  localparam logic [IDX_W-1:0] HOME_IDX = IDX_W'(QSTEPS / 2);

  typedef enum logic [1:0] {
    RES_HALF      = 2'b00,
    RES_QUARTER   = 2'b01,
    RES_EIGHTH    = 2'b10,
    RES_SIXTEENTH = 2'b11
  } res_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic             homeLoad;
    logic             stepGo;
    logic             forward;
    logic [IDX_W-1:0] delta;
  } ctlStrobe_t;

  // Half step is QSTEPS/2 index units; each finer mode halves it.
  function automatic logic [IDX_W-1:0] stepDelta(res_e r);
    return IDX_W'(QSTEPS / 2) >> r;
  endfunction

endpackage

// File: rtl/xlator_ctrl.sv
`timescale 1ns/1ps
module xlator_ctrl
  import xlator_pkg::*;
#(
  parameter int SETTLE_CYCLES = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stepIn,
  input  logic       dirIn,
  input  logic [1:0] modeSel,
  input  logic       resetReq,
  input  logic       sleepIn,
  output ctlStrobe_t strobe,
  output logic       driveEn
);

  localparam int CNT_W = (SETTLE_CYCLES < 1) ? 1 : $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYCLES);

  logic             stepPrev;
  logic [CNT_W-1:0] settleCnt;
  logic             settled;
  logic             stepRise;

  // Edge history, settle window and drive enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stepPrev  <= 1'b0;
      settleCnt <= SETTLE_LOAD;
      driveEn   <= 1'b0;
    end else begin
      stepPrev <= stepIn;
      driveEn  <= ~sleepIn;
      if (resetReq) begin
        settleCnt <= SETTLE_LOAD;
      end else if (settleCnt != '0) begin
        settleCnt <= settleCnt - CNT_W'(1);
      end
    end
  end

  assign settled  = (settleCnt == '0);
  assign stepRise = stepIn & ~stepPrev;

  // Direction and resolution are only consumed with an accepted edge.
  always_comb begin
    strobe.homeLoad = resetReq;
    strobe.stepGo   = stepRise & settled & ~resetReq;
    strobe.forward  = dirIn;
    strobe.delta    = stepDelta(res_e'(modeSel));
  end

endmodule

// File: rtl/xlator_sine.sv
`timescale 1ns/1ps
module xlator_sine
  import xlator_pkg::*;
(
  input  logic [IDX_W-1:0] angle,
  output logic [MAG_W:0]   code
);

  localparam int QB = IDX_W - 2;

  logic [QB:0]      fold;
  logic [MAG_W-1:0] mag;

  // Quarter-wave table: round(127*sin(k*pi/32)), k = 0..16.
  function automatic logic [MAG_W-1:0] quarterSin(logic [QB:0] k);
    logic [MAG_W-1:0] v;
    case (int'(k))
      0:  v = 7'd0;
      1:  v = 7'd12;
      2:  v = 7'd25;
      3:  v = 7'd37;
      4:  v = 7'd49;
      5:  v = 7'd60;
      6:  v = 7'd71;
      7:  v = 7'd81;
      8:  v = 7'd90;
      9:  v = 7'd98;
      10: v = 7'd106;
      11: v = 7'd112;
      12: v = 7'd117;
      13: v = 7'd122;
      14: v = 7'd125;
      15: v = 7'd126;
      16: v = 7'd127;
      default: v = '0;
    endcase
    return v;
  endfunction

  // Odd quadrants read the table mirrored.
  always_comb begin
    if (angle[QB]) begin
      fold = (QB+1)'(QSTEPS) - {1'b0, angle[QB-1:0]};
    end else begin
      fold = {1'b0, angle[QB-1:0]};
    end
    mag  = quarterSin(fold);
    code = {angle[IDX_W-1] & (mag != '0), mag};
  end

endmodule

// File: rtl/xlator_dpath.sv
`timescale 1ns/1ps
module xlator_dpath
  import xlator_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  ctlStrobe_t     strobe,
  output logic [MAG_W:0] phaseA,
  output logic [MAG_W:0] phaseB,
  output logic           monitor
);

  localparam int NPH = 2;

  logic [IDX_W-1:0] angleIdx;
  logic [MAG_W:0]   phaseCode [NPH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      angleIdx <= HOME_IDX;
    end else if (strobe.homeLoad) begin
      angleIdx <= HOME_IDX;
    end else if (strobe.stepGo) begin
      if (strobe.forward) begin
        angleIdx <= angleIdx + strobe.delta;
      end else begin
        angleIdx <= angleIdx - strobe.delta;
      end
    end
  end

  // Phase 0 (A) leads by a quarter cycle: cosine; phase 1 (B): sine.
  generate
    for (genvar p = 0; p < NPH; p++) begin : g_phase
      localparam logic [IDX_W-1:0] OFS = (p == 0) ? IDX_W'(QSTEPS) : '0;
      logic [MAG_W:0] code;
      xlator_sine u_sine (
        .angle (angleIdx + OFS),
        .code  (code)
      );
      assign phaseCode[p] = code;
    end
  endgenerate

  assign phaseA  = phaseCode[0];
  assign phaseB  = phaseCode[1];
  assign monitor = ~strobe.homeLoad &
                   (angleIdx[IDX_W-3:0] == HOME_IDX[IDX_W-3:0]);

endmodule

// File: rtl/stepper_xlator.sv
`timescale 1ns/1ps
module stepper_xlator
  import xlator_pkg::*;
#(
  parameter int SETTLE_CYCLES = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stepIn,
  input  logic       dirIn,
  input  logic [1:0] modeSel,
  input  logic       resetReq,
  input  logic       sleepIn,
  output logic [7:0] phaseA,
  output logic [7:0] phaseB,
  output logic       monitor,
  output logic       driveEn
);

  ctlStrobe_t strobe;

  xlator_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .stepIn   (stepIn),
    .dirIn    (dirIn),
    .modeSel  (modeSel),
    .resetReq (resetReq),
    .sleepIn  (sleepIn),
    .strobe   (strobe),
    .driveEn  (driveEn)
  );

  xlator_dpath u_dpath (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .phaseA  (phaseA),
    .phaseB  (phaseB),
    .monitor (monitor)
  );

endmodule

// File: rtl/xlator_checker.sv
`timescale 1ns/1ps
module xlator_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       stepIn,
  input logic       resetReq,
  input logic       sleepIn,
  input logic [7:0] phaseA,
  input logic [7:0] phaseB,
  input logic       monitor,
  input logic       driveEn
);

  a_r5_monitor_low_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    resetReq |-> !monitor);

  a_r4_home_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    resetReq |=> (phaseA == 8'h5A && phaseB == 8'h5A));

  a_r1_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!resetReq && $stable(stepIn)) |=> ($stable(phaseA) && $stable(phaseB)));

  a_r6_monitor_on_diagonal: assert property (@(posedge clk) disable iff (!rst_n)
    monitor |-> (phaseA[6:0] == 7'd90 && phaseB[6:0] == 7'd90));

  a_r9_first_edge_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(resetReq) |=> ($stable(phaseA) && $stable(phaseB)));

  a_r10_sleep_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    sleepIn |=> !driveEn);

endmodule

bind stepper_xlator xlator_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stepIn   (stepIn),
  .resetReq (resetReq),
  .sleepIn  (sleepIn),
  .phaseA   (phaseA),
  .phaseB   (phaseB),
  .monitor  (monitor),
  .driveEn  (driveEn)
);

// File: tb/sim_stepper_xlator.sv
`timescale 1ns/1ps
module sim_stepper_xlator;

  localparam int S = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stepIn = 1'b0;
  logic       dirIn = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       resetReq = 1'b0;
  logic       sleepIn = 1'b0;
  logic [7:0] phaseA, phaseB;
  logic       monitor, driveEn;

  int checks = 0;
  int fails = 0;
  int idxM = 8;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stepper_xlator #(.SETTLE_CYCLES(S)) u0 (
    .clk(clk), .rst_n(rst_n), .stepIn(stepIn), .dirIn(dirIn),
    .modeSel(modeSel), .resetReq(resetReq), .sleepIn(sleepIn),
    .phaseA(phaseA), .phaseB(phaseB), .monitor(monitor), .driveEn(driveEn)
  );

  function automatic logic [7:0] expCode(int idx, bit isA);
    real th = 2.0 * 3.14159265358979 * idx / 64.0;
    real v = isA ? $cos(th) : $sin(th);
    real a = (v < 0.0) ? -v : v;
    int m = $rtoi(a * 127.0 + 0.5);
    return {((m != 0) && (v < 0.0)), m[6:0]};
  endfunction

  task automatic expect1(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk(string tag);
    expect1({tag, " R7 phaseA"}, 32'(phaseA), 32'(expCode(idxM, 1'b1)));
    expect1({tag, " R7 phaseB"}, 32'(phaseB), 32'(expCode(idxM, 1'b0)));
    expect1({tag, " R6 monitor"}, 32'(monitor),
            32'(!resetReq && (idxM % 16 == 8)));
    expect1({tag, " R10 driveEn"}, 32'(driveEn), 32'(!sleepIn));
  endtask

  // Called at a negedge; returns at a negedge with stepIn low again.
  task automatic stepOnce(bit d, logic [1:0] m, bit accept, string tag);
    int inc;
    dirIn = d; modeSel = m; stepIn = 1'b1;
    @(negedge clk);
    inc = 8 >> m;
    if (accept) idxM = (idxM + 64 + (d ? inc : -inc)) % 64;
    chk(tag);
    stepIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic enterReset();
    resetReq = 1'b1;
    @(negedge clk);
    idxM = 8;
    chk("R4 R5 in reset");
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 power-up home");
    stepOnce(1'b1, 2'b00, 1'b0, "R9 step in power-up settle");
    repeat (S + 1) @(negedge clk);

    // R8 half-step sequence: alternating two-phase / one-phase.
    for (int i = 0; i < 8; i++) begin
      int nz;
      stepOnce(1'b1, 2'b00, 1'b1, "R8 half step");
      nz = int'(phaseA[6:0] != 0) + int'(phaseB[6:0] != 0);
      expect1("R8 phases driven", 32'(nz), (idxM % 16 == 8) ? 32'd2 : 32'd1);
    end
    expect1("R8 eight steps per cycle", 32'(phaseA), 32'h5A);

    // R3 reverse across zero at sixteenth resolution.
    for (int i = 0; i < 10; i++) stepOnce(1'b0, 2'b11, 1'b1, "R3 reverse wrap");
    expect1("R3 wrapped index 62 phaseB", 32'(phaseB), 32'(expCode(62, 1'b0)));

    // R2 no re-alignment: fine step then coarse steps.
    stepOnce(1'b1, 2'b11, 1'b1, "R2 fine step");
    stepOnce(1'b1, 2'b00, 1'b1, "R2 coarse from odd index");
    stepOnce(1'b1, 2'b01, 1'b1, "R2 quarter from odd index");
    stepOnce(1'b0, 2'b10, 1'b1, "R2 eighth reverse");

    // R1 level held high advances once only; dir/mode ignored meanwhile.
    dirIn = 1'b1; modeSel = 2'b01; stepIn = 1'b1;
    @(negedge clk);
    idxM = (idxM + 4) % 64;
    for (int i = 0; i < 5; i++) begin
      dirIn = ~dirIn; modeSel = modeSel + 2'd1;
      @(negedge clk);
      chk("R1 level high holds");
    end
    stepIn = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1 level low holds");
    end

    // R10 sleep: enable drops, steps still counted.
    sleepIn = 1'b1;
    @(negedge clk);
    chk("R10 sleep entry");
    stepOnce(1'b1, 2'b00, 1'b1, "R10 step during sleep");
    stepOnce(1'b1, 2'b10, 1'b1, "R10 step during sleep");
    sleepIn = 1'b0;
    @(negedge clk);
    chk("R10 wake");

    // R5 steps ignored while reset held.
    enterReset();
    stepOnce(1'b1, 2'b00, 1'b0, "R5 step in reset");
    // R9 boundary: edge S-1 after release ignored.
    resetReq = 1'b0;
    repeat (S - 1) @(negedge clk);
    stepOnce(1'b1, 2'b00, 1'b0, "R9 edge S-1 ignored");
    enterReset();
    resetReq = 1'b0;
    repeat (S) @(negedge clk);
    stepOnce(1'b1, 2'b11, 1'b1, "R9 edge S accepted");

    // Constrained random stepping.
    for (int i = 0; i < 400; i++) begin
      logic [1:0] m = 2'($urandom % 4);
      bit d = 1'($urandom % 2);
      if ($urandom % 8 == 0) begin
        sleepIn = ~sleepIn;
        @(negedge clk);
      end
      stepOnce(d, m, 1'b1, "R2 R3 random step");
      if ($urandom % 16 == 0) begin
        repeat (2) @(negedge clk);
        chk("R1 random idle");
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule